// File: doc/BRIEF.md
# Status Transfer Engine for a PHY-to-Link Interface

This block delivers status from the physical layer to the link layer controller over a 2-bit control bus and a 2-bit data bus. Both buses are clocked by the system clock. Four event flags are collected and held until they are delivered: arbitration-reset gap, subaction gap, bus reset and cable-power low. A register-read result is held in the same way. This includes the physical-ID word that is sent without a request once self-identification ends.

When the interface is idle, the engine claims the buses and drives the status code on the control lines. It then shifts the status word out two bits per clock. It sends a short 4-bit form that carries only the flags. It sends a long 16-bit form when a read result is pending, and that form adds the register address and data. An incoming packet can cut the transfer short. The engine then releases the buses and sends the whole word again later. A completed transfer is followed by one driven idle cycle before the buses are released.

The sequencer has three states:
- `ST_IDLE`: the buses are not driven.
- `ST_SEND`: the control lines carry the status code and one pair of bits goes out per clock.
- `ST_GAP`: the control and data lines are driven to 00 for one cycle.

The transitions are:
- start: `ST_IDLE` to `ST_SEND`.
- abort: `ST_SEND` to `ST_IDLE`, taken when a receive start arrives.
- finish: `ST_SEND` to `ST_GAP`, taken on the last pair when no receive start arrives.
- release: `ST_GAP` to `ST_IDLE`.

Top module: `stx_status_xfer`

## Requirements
- R1: After reset is released, `ctl_oe` and `d_oe` are 0 and stay 0 while nothing is pending.
- R2: A transfer starts at the clock edge where the engine is in `ST_IDLE`, `if_idle`=1, `rx_start`=0 and at least one flag or a read result is pending. From the next cycle `ctl_o`=01 with both enables high, and `d_o` already carries the first pair of bits.
- R3: Status word bit order: S[0] is the arbitration-reset gap, S[1] the subaction gap, S[2] bus reset, S[3] cable-power low, S[7:4] the register address, and S[15:8] the register data. On beat k, `d_o[0]`=S[2k] and `d_o[1]`=S[2k+1].
- R4: With only flags pending, the transfer lasts exactly 2 beats and carries S[3:0].
- R5: With a read result pending, the transfer lasts exactly 8 beats and carries the flags together with the address and data. This long form takes priority over a flags-only transfer.
- R6: `ctl_o` holds the status code 01 on every beat of a transfer. Of the control codes (00 idle, 01 status, 10 receive, 11 transmit grant), the engine drives only 00 and 01.
- R7: After the last beat, exactly one cycle follows with `ctl_o`=00, `d_o`=00 and both enables high. The enables are then low, so consecutive transfers are separated by at least one idle cycle.
- R8: If `rx_start`=1 during a beat, both enables are low in the next cycle and nothing pending is cleared. The full word is sent again once the interface is idle.
- R9: Event pulses set sticky flags. A flag is cleared only by a completed transfer whose snapshot held it. An event that arrives during a transfer is delivered by a later one.
- R10: A new read result replaces an older one that has not yet been delivered. A read result that arrives during a long transfer stays pending and is sent next. A delivered result is cleared.
- R11: While `if_idle`=0 or `rx_start`=1, no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_arb_gap | input | 1 | Pulse: arbitration-reset gap seen |
| ev_sub_gap | input | 1 | Pulse: subaction gap seen |
| ev_bus_rst | input | 1 | Pulse: bus reset started |
| ev_pwr_low | input | 1 | Pulse: cable power dropped low |
| rd_valid | input | 1 | Pulse: a register-read result is ready |
| rd_addr | input | ADDR_W | Register address of the result |
| rd_data | input | DATA_W | Register data of the result |
| rx_start | input | 1 | Incoming packet claims the interface |
| if_idle | input | 1 | Interface is idle and owned by the PHY |
| ctl_o | output | 2 | Control line value |
| ctl_oe | output | 1 | Control line drive enable |
| d_o | output | LANE_W | Data line value |
| d_oe | output | 1 | Data line drive enable |

## Verification
Two pairs of functions can meet in one cycle, and each pair is provoked directly.

The first pair is an abort and a finish. The bench raises `rx_start` exactly on the final beat of a short transfer. A correct engine must treat this as an abort: the buses are released with no idle cycle, and the same word is sent again.

The second pair is the arrival of new pending state and the clearing of old pending state. The bench pulses an event, or a fresh read result, during a transfer that is already running. It then checks that the completed transfer carries only the old snapshot and that a second transfer follows with the new content.

// File: rtl/stx_pkg.sv
package stx_pkg;
    // Sequencer states of the status engine
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } stx_state_t;

    // Control codes driven by this engine (10 receive / 11 grant belong to others)
    localparam logic [1:0] CTL_IDLE   = 2'b00;
    localparam logic [1:0] CTL_STATUS = 2'b01;
endpackage

// File: rtl/stx_pend.sv
module stx_pend #(
    parameter int FLAG_W = 4,
    parameter int RD_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] ev,
    input  logic              rd_valid,
    input  logic [RD_W-1:0]   rd_word_in,
    input  logic              snap,
    input  logic [FLAG_W-1:0] clr_flags,
    input  logic              clr_rd,
    output logic [FLAG_W-1:0] flags,
    output logic              rd_pend,
    output logic [RD_W-1:0]   rd_word
);
    // set when a read result arrived after the last snapshot
    logic rd_new;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags   <= '0;
            rd_pend <= 1'b0;
            rd_new  <= 1'b0;
            rd_word <= '0;
        end else begin
            flags <= (flags & ~clr_flags) | ev;
            if (rd_valid) begin
                rd_pend <= 1'b1;
                rd_word <= rd_word_in;
                rd_new  <= 1'b1;
            end else begin
                if (clr_rd && !rd_new) rd_pend <= 1'b0;
                if (snap)              rd_new  <= 1'b0;
            end
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~flags & ~$past(clr_flags)) == '0)); // R9
    AST_RD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_pend) && !rd_pend) |-> $past(clr_rd)); // R10
endmodule

// File: rtl/stx_seq.sv
module stx_seq
    import stx_pkg::*;
#(
    parameter int FLAG_W      = 4,
    parameter int RD_W        = 12,
    parameter int WORD_W      = 16,
    parameter int SHORT_BEATS = 2,
    parameter int LONG_BEATS  = 8,
    parameter int CNT_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_idle,
    input  logic              rx_start,
    input  logic [FLAG_W-1:0] flags,
    input  logic              rd_pend,
    input  logic [RD_W-1:0]   rd_word,
    output stx_state_t        state,
    output logic [CNT_W-1:0]  cnt,
    output logic [WORD_W-1:0] shadow,
    output logic              snap,
    output logic [FLAG_W-1:0] clr_flags,
    output logic              clr_rd
);
    stx_state_t state_nx;
    logic       long_q;
    logic       last_beat;
    logic       finish;
    logic       abort;

    always_comb begin
        snap      = (state == ST_IDLE) && if_idle && !rx_start && ((|flags) || rd_pend);
        last_beat = long_q ? (cnt == CNT_W'(LONG_BEATS - 1)) : (cnt == CNT_W'(SHORT_BEATS - 1));
        abort     = (state == ST_SEND) && rx_start;
        finish    = (state == ST_SEND) && !rx_start && last_beat;
        clr_flags = finish ? shadow[FLAG_W-1:0] : '0;
        clr_rd    = finish && long_q;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (snap)   state_nx = ST_SEND;
            ST_SEND: if (abort)  state_nx = ST_IDLE;
                     else if (finish) state_nx = ST_GAP;
            ST_GAP:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            shadow <= '0;
            long_q <= 1'b0;
        end else if (snap) begin
            cnt    <= '0;
            shadow <= {(rd_pend ? rd_word : {RD_W{1'b0}}), flags};
            long_q <= rd_pend;
        end else if (state == ST_SEND) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && $past(state) == ST_IDLE) |-> $past(if_idle && !rx_start)); // R11
    AST_SHORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !long_q) |-> (cnt < CNT_W'(SHORT_BEATS))); // R4
endmodule

// File: rtl/stx_status_xfer.sv
module stx_status_xfer
    import stx_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_arb_gap,
    input  logic              ev_sub_gap,
    input  logic              ev_bus_rst,
    input  logic              ev_pwr_low,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rx_start,
    input  logic              if_idle,
    output logic [1:0]        ctl_o,
    output logic              ctl_oe,
    output logic [LANE_W-1:0] d_o,
    output logic              d_oe
);
    localparam int FLAG_W      = 4;
    localparam int RD_W        = ADDR_W + DATA_W;
    localparam int WORD_W      = FLAG_W + RD_W;
    localparam int SHORT_BEATS = FLAG_W / LANE_W;
    localparam int LONG_BEATS  = WORD_W / LANE_W;
    localparam int CNT_W       = $clog2(LONG_BEATS);

    logic [FLAG_W-1:0] flags, clr_flags;
    logic              rd_pend, clr_rd, snap;
    logic [RD_W-1:0]   rd_word;
    stx_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] shadow;
    logic [LANE_W-1:0] lanes [LONG_BEATS];

    stx_pend #(.FLAG_W(FLAG_W), .RD_W(RD_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .ev({ev_pwr_low, ev_bus_rst, ev_sub_gap, ev_arb_gap}),
        .rd_valid(rd_valid), .rd_word_in({rd_data, rd_addr}),
        .snap(snap), .clr_flags(clr_flags), .clr_rd(clr_rd),
        .flags(flags), .rd_pend(rd_pend), .rd_word(rd_word)
    );

    stx_seq #(
        .FLAG_W(FLAG_W), .RD_W(RD_W), .WORD_W(WORD_W),
        .SHORT_BEATS(SHORT_BEATS), .LONG_BEATS(LONG_BEATS), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .if_idle(if_idle), .rx_start(rx_start),
        .flags(flags), .rd_pend(rd_pend), .rd_word(rd_word),
        .state(state), .cnt(cnt), .shadow(shadow), .snap(snap),
        .clr_flags(clr_flags), .clr_rd(clr_rd)
    );

    // split the snapshot into per-beat lanes, lowest bits first
    for (genvar g = 0; g < LONG_BEATS; g++) begin : g_lane
        assign lanes[g] = shadow[g*LANE_W +: LANE_W];
    end

    always_comb begin
        ctl_o  = CTL_IDLE;
        ctl_oe = 1'b0;
        d_o    = '0;
        d_oe   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SEND: begin
                ctl_o  = CTL_STATUS;
                ctl_oe = 1'b1;
                d_o    = lanes[cnt];
                d_oe   = 1'b1;
            end
            ST_GAP: begin
                ctl_oe = 1'b1;
                d_oe   = 1'b1;
            end
            default: ;
        endcase
    end

    AST_CTL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_oe |-> (ctl_o == CTL_IDLE || ctl_o == CTL_STATUS)); // R6
    AST_BEGIN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !$past(ctl_oe)) |-> (ctl_o == CTL_STATUS)); // R2
    AST_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && ctl_o == CTL_IDLE) |=> !ctl_oe); // R7
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && ctl_o == CTL_STATUS && rx_start) |=> !ctl_oe); // R8
endmodule

// File: tb/sim_stx_status_xfer.sv
module sim_stx_status_xfer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_arb_gap = 0, ev_sub_gap = 0, ev_bus_rst = 0, ev_pwr_low = 0;
    logic       rd_valid = 0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data = '0;
    logic       rx_start = 0;
    logic       if_idle = 0;
    logic [1:0] ctl_o;
    logic       ctl_oe;
    logic [1:0] d_o;
    logic       d_oe;
    int nchk = 0;
    int nbad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    stx_status_xfer u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_arb_gap(ev_arb_gap), .ev_sub_gap(ev_sub_gap),
        .ev_bus_rst(ev_bus_rst), .ev_pwr_low(ev_pwr_low),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
        .rx_start(rx_start), .if_idle(if_idle),
        .ctl_o(ctl_o), .ctl_oe(ctl_oe), .d_o(d_o), .d_oe(d_oe)
    );

    // {flags[3:0], rd, addr[3:0], data[7:0], expected word[15:0], beats[3:0]}
    localparam logic [36:0] VECS [6] = '{
        {4'b0001, 1'b0, 4'h0, 8'h00, 16'h0001, 4'd2},
        {4'b1010, 1'b0, 4'h0, 8'h00, 16'h000A, 4'd2},
        {4'b1111, 1'b0, 4'h0, 8'h00, 16'h000F, 4'd2},
        {4'b0000, 1'b1, 4'h3, 8'hA5, 16'hA530, 4'd8},
        {4'b0110, 1'b1, 4'hF, 8'h5C, 16'h5CF6, 4'd8},
        {4'b0100, 1'b1, 4'h0, 8'h80, 16'h8004, 4'd8}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] f, input bit rd, input logic [3:0] a, input logic [7:0] dv);
        {ev_pwr_low, ev_bus_rst, ev_sub_gap, ev_arb_gap} = f;
        rd_valid = rd; rd_addr = a; rd_data = dv;
        @(negedge clk);
        {ev_pwr_low, ev_bus_rst, ev_sub_gap, ev_arb_gap} = '0;
        rd_valid = 0;
    endtask

    task automatic wait_oe(input string req);
        bit seen = 0;
        for (int j = 0; j < 30; j++) begin
            if (ctl_oe) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen && ctl_o == 2'b01, req, {ctl_oe, ctl_o}, 3'b101);
    endtask

    task automatic capture(output logic [15:0] s, output int b, output bit gap_ok, output bit rel_ok);
        s = '0; b = 0;
        while (ctl_oe && d_oe && ctl_o == 2'b01 && b < 8) begin
            s[2*b] = d_o[0];
            s[2*b+1] = d_o[1];
            b++;
            @(negedge clk);
        end
        gap_ok = ctl_oe && d_oe && ctl_o == 2'b00 && d_o == 2'b00;
        @(negedge clk);
        rel_ok = !ctl_oe && !d_oe;
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (ctl_oe || d_oe) seen = 1;
        end
        chk(!seen, req, seen, 0);
    endtask

    task automatic xfer_expect(input logic [15:0] es, input int eb, input string req);
        logic [15:0] s; int b; bit g, r;
        wait_oe({req, " start"});
        capture(s, b, g, r);
        chk(s == es, {req, " word"}, s, es);
        chk(b == eb, {req, " beats"}, b, eb);
        chk(g, "R7 gap", g, 1);
        chk(r, "R7 release", r, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!ctl_oe && !d_oe, "R1 in reset", {ctl_oe, d_oe}, 0);
        rst_n = 1;
        if_idle = 1;
        quiet(5, "R1 after reset");

        // table walk: R3, R4, R5 (priority when both pending)
        for (int i = 0; i < 6; i++) begin
            logic [36:0] v;
            v = VECS[i];
            if_idle = 0;
            pulse(v[36:33], v[32], v[31:28], v[27:20]);
            if_idle = 1;
            xfer_expect(v[19:4], int'(v[3:0]), v[32] ? "R5 R3 long" : "R4 R3 short");
            quiet(6, "R9 R10 nothing left pending");
        end

        // R11: interface busy blocks start
        if_idle = 0;
        pulse(4'b0100, 0, 0, 0);
        quiet(5, "R11 if_idle low");
        if_idle = 1;
        xfer_expect(16'h0004, 2, "R11 after idle");

        // R11: receive start blocks start
        rx_start = 1;
        pulse(4'b1000, 0, 0, 0);
        quiet(5, "R11 rx_start high");
        rx_start = 0;
        xfer_expect(16'h0008, 2, "R11 after rx");

        // R8: abort mid long transfer, then full retry
        if_idle = 0;
        pulse(4'b0011, 1, 4'h9, 8'h3C);
        if_idle = 1;
        wait_oe("R8 first try");
        repeat (2) @(negedge clk);
        rx_start = 1;
        @(negedge clk);
        chk(!ctl_oe && !d_oe, "R8 release on abort", {ctl_oe, d_oe}, 0);
        rx_start = 0;
        xfer_expect(16'h3C93, 8, "R8 retry");

        // R8: abort on final beat of short transfer wins over finish
        if_idle = 0;
        pulse(4'b0010, 0, 0, 0);
        if_idle = 1;
        wait_oe("R8 last-beat try");
        @(negedge clk);
        rx_start = 1;
        @(negedge clk);
        chk(!ctl_oe && !d_oe, "R8 last-beat abort", {ctl_oe, d_oe}, 0);
        rx_start = 0;
        xfer_expect(16'h0002, 2, "R8 last-beat retry");

        // R9: event during transfer delivered later
        if_idle = 0;
        pulse(4'b0001, 0, 0, 0);
        if_idle = 1;
        wait_oe("R9 first");
        ev_bus_rst = 1;
        fork begin @(negedge clk); ev_bus_rst = 0; end join_none
        begin
            logic [15:0] s; int b; bit g, r;
            capture(s, b, g, r);
            chk(s == 16'h0001 && b == 2, "R9 snapshot only", s, 16'h0001);
            chk(g && r, "R7 gap before next", {g, r}, 2'b11);
        end
        xfer_expect(16'h0004, 2, "R9 late event");

        // R10: newer read result replaces older undelivered one
        if_idle = 0;
        pulse(4'b0000, 1, 4'h2, 8'h11);
        pulse(4'b0000, 1, 4'h5, 8'hEE);
        if_idle = 1;
        xfer_expect(16'hEE50, 8, "R10 overwrite");
        quiet(6, "R10 cleared");

        // R10: read result arriving during a long transfer is sent next
        if_idle = 0;
        pulse(4'b0000, 1, 4'h1, 8'h11);
        if_idle = 1;
        wait_oe("R10 first");
        rd_valid = 1; rd_addr = 4'h7; rd_data = 8'h77;
        fork begin @(negedge clk); rd_valid = 0; end join_none
        begin
            logic [15:0] s; int b; bit g, r;
            capture(s, b, g, r);
            chk(s == 16'h1110 && b == 8, "R10 old result", s, 16'h1110);
        end
        xfer_expect(16'h7770, 8, "R10 new result");
        quiet(6, "R10 all delivered");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule